// File: doc/BRIEF.md
# Idle-Driven Core Boost Controller

This block shares a fixed number of fast-clock slots among the cores of a multicore cluster. It does not look at what work a core runs: every core that is executing is treated as equally worth speeding up. Each core raises a one-cycle halt pulse when it drops into light sleep and a one-cycle wake pulse when it resumes. The block answers with one level request per core, where 1 means fast and 0 means slow. The voltage and frequency machinery outside the block acts on these requests.

When a fast core halts, the block drops it to slow. In the same clock edge it hands the freed slot to another executing core that is still slow, and a free-running LFSR picks which one. When a sleeping core wakes, it gets a fast slot only if fewer than `BUDGET` cores are fast. Events are held as pending per core and served one per clock, so several cores can report in the same cycle without any report being lost.

Top module: `idle_boost_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, every core is asleep and every `fast_o` bit is 0.
- R2: A halt or wake pulse seen at a rising edge is held as pending. One pending event is served per clock, starting with the next rising edge. All pending halts are served before any pending wake, and within each kind the lowest core index goes first. A new pulse on a core whose event of the same kind is already pending merges with it.
- R3: Serving a wake on a sleeping core makes it active. It becomes fast in the same edge if, before that edge, fewer than `BUDGET` cores were fast. Otherwise it stays slow.
- R4: A wake served on an active core, or a halt served on a sleeping core, changes no level and no core state.
- R5: A halt served on an active slow core marks it asleep and changes no `fast_o` bit.
- R6: A halt served on a fast core clears its `fast_o` bit and marks it asleep. In the same edge, one other active slow core is set fast. The block searches upward from start index `s = lfsr mod N`, wrapping round, and takes the first candidate it finds.
- R7: If no active slow core other than the halting one exists, the freed slot stays unused, so the fast count drops by one.
- R8: The number of fast cores never exceeds `BUDGET`, and a sleeping core is never fast. At most one `fast_o` bit rises per clock.
- R9: The LFSR is 16 bits wide and resets to 0xACE1. It advances on every clock after reset by shifting left, with bit 0 taking the XOR of bits 15, 13, 12 and 10. The value it holds before an edge gives the start index used at that edge. It is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_evt | input | N | Per-core one-cycle pulse: core entered light sleep |
| wake_evt | input | N | Per-core one-cycle pulse: core resumed execution |
| fast_o | output | N | Per-core level request, 1 = fast, 0 = slow |

## Verification
The hardest cases to reach are a halt of a fast core whose search start falls on a core that cannot be chosen, and a halt that finds no candidate at all. Both depend on the LFSR phase and on which cores are asleep. The bench first wakes a few cores one at a time to fill the budget. It then halts fast cores while slow active cores remain, so the wrap-round search is exercised, and it drains the slow cores so that a freed slot is left unused. Long stretches of sparse random halt and wake pulses, including pulses on the same cores and in the same cycle, cover the pending-order and merge cases. A behavioural model tracks the LFSR phase so the chosen core can be predicted on every cycle.

// File: rtl/boost_pkg.sv
package boost_pkg;

  // Kind of event being served in the current cycle
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_HALT = 2'd1,
    EV_WAKE = 2'd2
  } ev_kind_e;

  // Pseudo-random source: 16-bit Fibonacci register, taps 15,13,12,10
  localparam int unsigned     RND_W    = 16;
  localparam logic [RND_W-1:0] RND_TAPS = 16'hB400;
  localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;

endpackage

// File: rtl/boost_lfsr.sv
module boost_lfsr #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400,
  parameter logic [W-1:0]    SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = {state_q[W-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/boost_evt_sel.sv
module boost_evt_sel
  import boost_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     halt_evt,
  input  logic [N-1:0]     wake_evt,
  output ev_kind_e         kind_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [N-1:0]     halt_pend_q, halt_pend_d;
  logic [N-1:0]     wake_pend_q, wake_pend_d;
  logic [N-1:0]     sel_onehot;
  logic [N-1:0]     halt_clr, wake_clr;
  logic             pend_en;
  ev_kind_e         kind;
  logic [IDX_W-1:0] idx;
  logic             hit;

  // Priority: halts before wakes, lowest index first
  always_comb begin
    kind = EV_NONE;
    idx  = '0;
    hit  = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (!hit && halt_pend_q[i]) begin
        kind = EV_HALT;
        idx  = IDX_W'(i);
        hit  = 1'b1;
      end
    end
    for (int i = 0; i < int'(N); i++) begin
      if (!hit && wake_pend_q[i]) begin
        kind = EV_WAKE;
        idx  = IDX_W'(i);
        hit  = 1'b1;
      end
    end
  end

  always_comb begin
    sel_onehot  = {{(N-1){1'b0}}, 1'b1} << idx;
    halt_clr    = (kind == EV_HALT) ? sel_onehot : '0;
    wake_clr    = (kind == EV_WAKE) ? sel_onehot : '0;
    halt_pend_d = (halt_pend_q & ~halt_clr) | halt_evt;
    wake_pend_d = (wake_pend_q & ~wake_clr) | wake_evt;
    pend_en     = hit | (|halt_evt) | (|wake_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_pend_q <= '0;
      wake_pend_q <= '0;
    end else if (pend_en) begin
      halt_pend_q <= halt_pend_d;
      wake_pend_q <= wake_pend_d;
    end
  end

  assign kind_o = kind;
  assign idx_o  = idx;

endmodule

// File: rtl/boost_pick.sv
module boost_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand_i,
  input  logic [IDX_W-1:0] start_i,
  output logic             found_o,
  output logic [IDX_W-1:0] pick_o
);

  // Rotating first-one search beginning at start_i
  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    for (int j = 0; j < int'(N); j++) begin
      if (!found_o && cand_i[(int'(start_i) + j) % int'(N)]) begin
        found_o = 1'b1;
        pick_o  = IDX_W'((int'(start_i) + j) % int'(N));
      end
    end
  end

endmodule

// File: rtl/idle_boost_ctrl.sv
module idle_boost_ctrl
  import boost_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned BUDGET = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] halt_evt,
  input  logic [N-1:0] wake_evt,
  output logic [N-1:0] fast_o
);

  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned CNT_W = $clog2(N + 1);
  localparam logic [RND_W-1:0] N_RND = RND_W'(N);

  logic [N-1:0]     active_q, active_d;
  logic [N-1:0]     fast_q, fast_d;
  logic             lvl_en;
  ev_kind_e         kind;
  logic [IDX_W-1:0] idx;
  logic [RND_W-1:0] lfsr_q;
  logic [IDX_W-1:0] start;
  logic [N-1:0]     cand;
  logic             found;
  logic [IDX_W-1:0] pick;
  logic [CNT_W-1:0] fast_cnt;

  boost_lfsr #(
    .W    (RND_W),
    .TAPS (RND_TAPS),
    .SEED (RND_SEED)
  ) rnd_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_o (lfsr_q)
  );

  boost_evt_sel #(
    .N     (N),
    .IDX_W (IDX_W)
  ) sel_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_evt (halt_evt),
    .wake_evt (wake_evt),
    .kind_o   (kind),
    .idx_o    (idx)
  );

  // Promotion candidates: executing, slow, and not the core being served
  for (genvar g = 0; g < int'(N); g++) begin : g_cand
    assign cand[g] = active_q[g] & ~fast_q[g] & (idx != IDX_W'(g));
  end

  assign start = IDX_W'(lfsr_q % N_RND);

  boost_pick #(
    .N     (N),
    .IDX_W (IDX_W)
  ) pick_i (
    .cand_i  (cand),
    .start_i (start),
    .found_o (found),
    .pick_o  (pick)
  );

  always_comb begin
    fast_cnt = '0;
    for (int i = 0; i < int'(N); i++) begin
      fast_cnt = fast_cnt + CNT_W'(fast_q[i]);
    end
  end

  // Next-state for per-core activity and level
  always_comb begin
    active_d = active_q;
    fast_d   = fast_q;
    lvl_en   = 1'b0;
    unique case (kind)
      EV_HALT: begin
        if (active_q[idx]) begin
          lvl_en        = 1'b1;
          active_d[idx] = 1'b0;
          if (fast_q[idx]) begin
            fast_d[idx] = 1'b0;
            if (found) begin
              fast_d[pick] = 1'b1;
            end
          end
        end
      end
      EV_WAKE: begin
        if (!active_q[idx]) begin
          lvl_en        = 1'b1;
          active_d[idx] = 1'b1;
          if (fast_cnt < CNT_W'(BUDGET)) begin
            fast_d[idx] = 1'b1;
          end
        end
      end
      default: begin
        lvl_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      fast_q   <= '0;
    end else if (lvl_en) begin
      active_q <= active_d;
      fast_q   <= fast_d;
    end
  end

  assign fast_o = fast_q;

endmodule

// File: rtl/boost_chk.sv
module boost_chk #(
  parameter int unsigned N      = 8,
  parameter int unsigned BUDGET = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] fast,
  input logic [N-1:0] active,
  input logic [15:0]  lfsr
);

  // R8
  budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fast) <= BUDGET);

  // R8
  sleep_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast & ~active) == '0);

  // R8
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fast & ~$past(fast)) <= 1);

  // R6
  drop_sleeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~fast & $past(fast)) & active) == '0);

  // R9
  rnd_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000);

endmodule

bind idle_boost_ctrl boost_chk #(
  .N      (N),
  .BUDGET (BUDGET)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .fast   (fast_o),
  .active (active_q),
  .lfsr   (lfsr_q)
);

// File: tb/idle_boost_ctrl_tb_top.sv
module idle_boost_ctrl_tb_top;

  localparam int N      = 8;
  localparam int BUDGET = 3;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] halt_evt;
  logic [N-1:0] wake_evt;
  logic [N-1:0] fast_o;

  int    total;
  int    bad;
  int    cyc;
  bit    chk_on;
  string cur_req;

  // Reference state
  logic [N-1:0] m_act, m_fst, m_hp, m_wp;
  logic [15:0]  m_lfsr;

  idle_boost_ctrl #(.N(N), .BUDGET(BUDGET)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_evt (halt_evt),
    .wake_evt (wake_evt),
    .fast_o   (fast_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural model (R2 R3 R4 R5 R6 R7 R9)
  always @(posedge clk or negedge rst_n) begin
    int h, w, s, p, k;
    if (!rst_n) begin
      m_act = '0; m_fst = '0; m_hp = '0; m_wp = '0;
      m_lfsr = 16'hACE1;
    end else begin
      h = -1; w = -1;
      for (int i = N - 1; i >= 0; i--) begin
        if (m_hp[i]) h = i;
        if (m_wp[i]) w = i;
      end
      if (h >= 0) begin
        m_hp[h] = 1'b0;
        if (m_act[h]) begin
          if (m_fst[h]) begin
            s = int'(m_lfsr) % N;
            p = -1;
            for (int j = 0; j < N; j++) begin
              k = (s + j) % N;
              if (p < 0 && k != h && m_act[k] && !m_fst[k]) p = k;
            end
            m_fst[h] = 1'b0;
            if (p >= 0) m_fst[p] = 1'b1;
          end
          m_act[h] = 1'b0;
        end
      end else if (w >= 0) begin
        m_wp[w] = 1'b0;
        if (!m_act[w]) begin
          m_act[w] = 1'b1;
          if ($countones(m_fst) < BUDGET) m_fst[w] = 1'b1;
        end
      end
      m_hp = m_hp | halt_evt;
      m_wp = m_wp | wake_evt;
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      total++;
      if (fast_o !== m_fst) begin
        bad++;
        $display("FAIL %s fast_o actual=%b expected=%b", cur_req, fast_o, m_fst);
      end
      total++;
      if ($countones(fast_o) > BUDGET) begin
        bad++;
        $display("FAIL R8 fast count actual=%0d expected<=%0d", $countones(fast_o), BUDGET);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      bad++;
      total++;
      $display("FAIL watchdog cycles actual=%0d expected<=60000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulse(input logic [N-1:0] h, input logic [N-1:0] w);
    @(negedge clk);
    halt_evt = h;
    wake_evt = w;
    @(negedge clk);
    halt_evt = '0;
    wake_evt = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; chk_on = 0;
    cur_req = "R1";
    rst_n = 1'b0;
    halt_evt = '0;
    wake_evt = '0;
    repeat (3) @(negedge clk);
    total++;
    if (fast_o !== '0) begin
      bad++;
      $display("FAIL R1 reset fast_o actual=%b expected=%b", fast_o, {N{1'b0}});
    end
    rst_n = 1'b1;
    chk_on = 1;
    repeat (2) @(negedge clk);

    // R3: wakes one at a time fill the budget, the rest stay slow
    cur_req = "R3";
    for (int i = 0; i < 5; i++) pulse('0, N'(1) << i);

    // R4: wake of active cores ignored
    cur_req = "R4";
    pulse('0, 8'b0000_0011);

    // R5: halt of a slow active core
    cur_req = "R5";
    pulse(8'b0001_0000, '0);

    // R6 R9: halts of fast cores move the slot
    cur_req = "R6";
    pulse('0, 8'b1110_0000);
    pulse(8'b0000_0001, '0);
    pulse(8'b0000_0010, '0);
    pulse('0, 8'b0000_0011);
    pulse(8'b0000_0100, '0);

    // R7: drain slow cores then halt fast ones
    cur_req = "R7";
    for (int i = 0; i < N; i++) pulse(N'(1) << i, '0);

    // R4: halt of sleeping cores ignored
    cur_req = "R4";
    pulse(8'b1111_1111, '0);
    pulse('0, 8'b0000_0001);

    // R2: simultaneous and merged events
    cur_req = "R2";
    pulse(8'b0000_0001, 8'b1111_1111);
    pulse(8'b1010_1010, 8'b0000_0001);

    // R8: sparse random traffic
    cur_req = "R8";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      halt_evt = N'($urandom & $urandom & $urandom);
      wake_evt = N'($urandom & $urandom & $urandom);
    end
    @(negedge clk);
    halt_evt = '0;
    wake_evt = '0;
    repeat (40) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule